// File: doc/BRIEF.md
# Legacy System Control Port Bank

This block is a bank of byte-wide control and status ports on a simple I/O bus. The bus has an address, a write strobe, a read strobe, write data and registered read data. The bank decodes one special port at 0x092 and a window of board-control ports between 0x800 and 0x851.

Writes to these ports do the following:
- drive a level reset request and a little-endian mode flag;
- drive a disk-activity light;
- load a 4-bit cache-control field;
- send single-cycle lock-toggle pulses on two channels to an external non-volatile memory;
- load a map-type bit.

Reads return fixed identification and equipment bytes, or the stored fields.

The map-type bit also steers a combinational address translator. A CPU address that falls inside the 8 MB I/O window at 0x80000000 is turned into a 16-bit port address. With the bit clear, the low 16 bits of the offset are used as they are. With the bit set, a sparse layout packs the page bits down onto the byte-in-page bits.

Bus handling is built around a three-state phase machine: PH_IDLE, PH_WRITE and PH_READ. Every clock the next phase is chosen from the strobes, with write taking priority over read:
- IDLE->WRITE, READ->WRITE and WRITE->WRITE on a write strobe;
- IDLE->READ, WRITE->READ and READ->READ on a read strobe alone;
- any state->IDLE with no strobe.

The output process decodes the phase together with the latched port. A lock pulse is high only in PH_WRITE for the matching port.

Top module: `sysctl_bank`

## Requirements
- R1: While reset is high and on the first cycle after it, all of the following are 0: rst_req, le_mode, disk_led, cache_ctl, both lock pulses, and io_rdata.
- R2: A write to port 0x092 copies data bit 0 to rst_req and data bit 1 to le_mode. A read of 0x092 returns 0x00.
- R3: Reads of ports 0x800, 0x802 and 0x803 return 0xEF, 0xAD and 0xE0. Writes to these ports change nothing.
- R4: A write to port 0x808 sets disk_led from data bit 0 and leaves all other state as it was.
- R5: A write to 0x810 makes lock_pulse_a high for exactly the one cycle after the strobe. A write to 0x812 does the same for lock_pulse_b. The data value is ignored, and the two pulses are never high together.
- R6: Reads return these fixed bytes: 0x80C gives 0x3C, 0x810 gives 0x39, 0x818 gives 0x00 and 0x823 gives 0x03.
- R7: A write to 0x81C stores data bits 3:0 in cache_ctl. A read of 0x81C returns that field in bits 3:0, with bits 7:4 zero.
- R8: A write to 0x850 stores data bit 0 as the map-type bit. A read of 0x850 returns that bit in bit 0, with the other bits zero.
- R9: With the map-type bit at 0, win_port equals cpu_addr[15:0]. With it at 1, win_port equals {cpu_addr[22:12], cpu_addr[4:0]}.
- R10: win_hit is 1 exactly when cpu_addr lies in the range 0x80000000 to 0x807FFFFF.
- R11: A read of any undecoded port returns 0xFF. This includes 0x808, 0x812, 0x814 and 0x830. Writes to undecoded ports and to 0x814 change no state.
- R12: io_rdata updates on the clock edge that samples the read strobe. It holds its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | Port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cpu_addr | input | 32 | CPU-side address for translation |
| win_hit | output | 1 | cpu_addr is inside the I/O window |
| win_port | output | 16 | Translated port address |
| rst_req | output | 1 | Level reset request |
| le_mode | output | 1 | Little-endian mode flag |
| disk_led | output | 1 | Disk-activity light |
| cache_ctl | output | 4 | Cache-control field |
| lock_pulse_a | output | 1 | Lock-toggle pulse, channel 1 |
| lock_pulse_b | output | 1 | Lock-toggle pulse, channel 2 |

## Verification
Each effect of a strobe is due on the first clock edge after it, so it becomes visible one cycle later:
- stored flags, the cache field and the map-type bit take their new values;
- read data appears;
- a lock pulse rises, and it is low again on the cycle after that.

The translation outputs are combinational, so they are due in the same cycle that cpu_addr changes. The driver stamps every expected item with the cycle number in which its result is due. The monitor compares an item only when the cycle counter reaches that stamp, and samples two time units after the edge. To prove that a lock pulse and a read value do not linger, the driver also queues items for the following idle cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int PORT_W = 16;

    localparam logic [PORT_W-1:0] A_SPECIAL = 16'h0092;
    localparam logic [PORT_W-1:0] A_ID_CPU  = 16'h0800;
    localparam logic [PORT_W-1:0] A_ID_FEAT = 16'h0802;
    localparam logic [PORT_W-1:0] A_ID_STAT = 16'h0803;
    localparam logic [PORT_W-1:0] A_LIGHT   = 16'h0808;
    localparam logic [PORT_W-1:0] A_EQUIP   = 16'h080C;
    localparam logic [PORT_W-1:0] A_LOCK1   = 16'h0810;
    localparam logic [PORT_W-1:0] A_LOCK2   = 16'h0812;
    localparam logic [PORT_W-1:0] A_INVAL   = 16'h0814;
    localparam logic [PORT_W-1:0] A_KEY     = 16'h0818;
    localparam logic [PORT_W-1:0] A_CACHE   = 16'h081C;
    localparam logic [PORT_W-1:0] A_L2STAT  = 16'h0823;
    localparam logic [PORT_W-1:0] A_MAP     = 16'h0850;

    localparam logic [7:0] V_ID_CPU  = 8'hEF;
    localparam logic [7:0] V_ID_FEAT = 8'hAD;
    localparam logic [7:0] V_ID_STAT = 8'hE0;
    localparam logic [7:0] V_EQUIP   = 8'h3C;
    localparam logic [7:0] V_XFEAT   = 8'h39;
    localparam logic [7:0] V_KEY     = 8'h00;
    localparam logic [7:0] V_L2STAT  = 8'h03;
    localparam logic [7:0] V_SPECIAL = 8'h00;
    localparam logic [7:0] V_NONE    = 8'hFF;

    typedef enum logic [3:0] {
        PT_NONE,
        PT_SPECIAL,
        PT_ID_CPU,
        PT_ID_FEAT,
        PT_ID_STAT,
        PT_LIGHT,
        PT_EQUIP,
        PT_LOCK1,
        PT_LOCK2,
        PT_INVAL,
        PT_KEY,
        PT_CACHE,
        PT_L2STAT,
        PT_MAP
    } port_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WRITE,
        PH_READ
    } phase_e;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [PORT_W-1:0] addr,
    output port_e             port
);

    always_comb begin
        unique case (addr)
            A_SPECIAL: port = PT_SPECIAL;
            A_ID_CPU:  port = PT_ID_CPU;
            A_ID_FEAT: port = PT_ID_FEAT;
            A_ID_STAT: port = PT_ID_STAT;
            A_LIGHT:   port = PT_LIGHT;
            A_EQUIP:   port = PT_EQUIP;
            A_LOCK1:   port = PT_LOCK1;
            A_LOCK2:   port = PT_LOCK2;
            A_INVAL:   port = PT_INVAL;
            A_KEY:     port = PT_KEY;
            A_CACHE:   port = PT_CACHE;
            A_L2STAT:  port = PT_L2STAT;
            A_MAP:     port = PT_MAP;
            default:   port = PT_NONE;
        endcase
    end

endmodule

// File: rtl/sysctl_xlate.sv
module sysctl_xlate #(
    parameter int          CPU_AW   = 32,
    parameter int          WIN_LOG2 = 23,
    parameter int          PAGE_LSB = 12,
    parameter int          OUT_W    = 16,
    parameter logic [31:0] WIN_BASE = 32'h8000_0000
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              sparse,
    output logic              hit,
    output logic [OUT_W-1:0]  port
);

    localparam int HI_BITS = WIN_LOG2 - PAGE_LSB;
    localparam int LO_BITS = OUT_W - HI_BITS;
    localparam int TAG_W   = CPU_AW - WIN_LOG2;

    logic [WIN_LOG2-1:0] offset;
    logic [TAG_W-1:0]    tag;
    logic [OUT_W-1:0]    flat_port;
    logic [OUT_W-1:0]    sparse_port;

    assign offset      = cpu_addr[WIN_LOG2-1:0];
    assign tag         = cpu_addr[CPU_AW-1:WIN_LOG2];
    assign hit         = (tag == WIN_BASE[CPU_AW-1:WIN_LOG2]);
    assign flat_port   = offset[OUT_W-1:0];
    assign sparse_port = {offset[WIN_LOG2-1:PAGE_LSB], offset[LO_BITS-1:0]};
    assign port        = sparse ? sparse_port : flat_port;

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CACHE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic               rd,
    input  port_e              port,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               rst_req,
    output logic               le_mode,
    output logic               disk_led,
    output logic [CACHE_W-1:0] cache_ctl,
    output logic               map_sparse,
    output logic               lock_a,
    output logic               lock_b
);

    localparam int PAD_W = DATA_W - CACHE_W;

    phase_e phase_q, phase_d;
    port_e  port_q;
    logic [DATA_W-1:0] read_val;
    logic unused_wbits;

    assign unused_wbits = &{1'b0, wdata[DATA_W-1:CACHE_W]};

    // next phase: write wins over read
    always_comb begin
        unique case (phase_q)
            PH_IDLE, PH_WRITE, PH_READ: begin
                if (wr)      phase_d = PH_WRITE;
                else if (rd) phase_d = PH_READ;
                else         phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            port_q  <= PT_NONE;
        end else begin
            phase_q <= phase_d;
            port_q  <= port;
        end
    end

    // outputs decoded from state
    always_comb begin
        lock_a = 1'b0;
        lock_b = 1'b0;
        unique case (phase_q)
            PH_WRITE: begin
                lock_a = (port_q == PT_LOCK1);
                lock_b = (port_q == PT_LOCK2);
            end
            PH_IDLE, PH_READ: begin
                lock_a = 1'b0;
                lock_b = 1'b0;
            end
            default: begin
                lock_a = 1'b0;
                lock_b = 1'b0;
            end
        endcase
    end

    // stored control fields
    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req    <= 1'b0;
            le_mode    <= 1'b0;
            disk_led   <= 1'b0;
            cache_ctl  <= '0;
            map_sparse <= 1'b0;
        end else if (wr) begin
            unique case (port)
                PT_SPECIAL: begin
                    rst_req <= wdata[0];
                    le_mode <= wdata[1];
                end
                PT_LIGHT: disk_led   <= wdata[0];
                PT_CACHE: cache_ctl  <= wdata[CACHE_W-1:0];
                PT_MAP:   map_sparse <= wdata[0];
                default: ;
            endcase
        end
    end

    // read value selection
    always_comb begin
        unique case (port)
            PT_SPECIAL: read_val = V_SPECIAL;
            PT_ID_CPU:  read_val = V_ID_CPU;
            PT_ID_FEAT: read_val = V_ID_FEAT;
            PT_ID_STAT: read_val = V_ID_STAT;
            PT_EQUIP:   read_val = V_EQUIP;
            PT_LOCK1:   read_val = V_XFEAT;
            PT_KEY:     read_val = V_KEY;
            PT_CACHE:   read_val = {{PAD_W{1'b0}}, cache_ctl};
            PT_L2STAT:  read_val = V_L2STAT;
            PT_MAP:     read_val = {{(DATA_W-1){1'b0}}, map_sparse};
            default:    read_val = V_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= read_val;
    end

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CACHE_W  = 4,
    parameter int CPU_AW   = 32,
    parameter int WIN_LOG2 = 23,
    parameter int PAGE_LSB = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PORT_W-1:0]  io_addr,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [DATA_W-1:0]  io_wdata,
    output logic [DATA_W-1:0]  io_rdata,
    input  logic [CPU_AW-1:0]  cpu_addr,
    output logic               win_hit,
    output logic [PORT_W-1:0]  win_port,
    output logic               rst_req,
    output logic               le_mode,
    output logic               disk_led,
    output logic [CACHE_W-1:0] cache_ctl,
    output logic               lock_pulse_a,
    output logic               lock_pulse_b
);

    port_e port_sel;
    logic  map_sparse;

    sysctl_decode u_decode (
        .addr (io_addr),
        .port (port_sel)
    );

    sysctl_regs #(
        .DATA_W  (DATA_W),
        .CACHE_W (CACHE_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (io_wr),
        .rd         (io_rd),
        .port       (port_sel),
        .wdata      (io_wdata),
        .rdata      (io_rdata),
        .rst_req    (rst_req),
        .le_mode    (le_mode),
        .disk_led   (disk_led),
        .cache_ctl  (cache_ctl),
        .map_sparse (map_sparse),
        .lock_a     (lock_pulse_a),
        .lock_b     (lock_pulse_b)
    );

    sysctl_xlate #(
        .CPU_AW   (CPU_AW),
        .WIN_LOG2 (WIN_LOG2),
        .PAGE_LSB (PAGE_LSB),
        .OUT_W    (PORT_W)
    ) u_xlate (
        .cpu_addr (cpu_addr),
        .sparse   (map_sparse),
        .hit      (win_hit),
        .port     (win_port)
    );

endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] io_addr,
    input logic        io_wr,
    input logic        io_rd,
    input logic [7:0]  io_wdata,
    input logic [7:0]  io_rdata,
    input logic [31:0] cpu_addr,
    input logic        win_hit,
    input logic        rst_req,
    input logic        lock_pulse_a,
    input logic        lock_pulse_b
);

    p_rst_set_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(io_wr) && $past(io_addr) == 16'h0092 && !$past(rst))
        |-> rst_req == $past(io_wdata[0]));

    p_rst_keep_r2: assert property (@(posedge clk) disable iff (rst)
        ((!$past(io_wr) || $past(io_addr) != 16'h0092) && !$past(rst))
        |-> $stable(rst_req));

    p_lock_cause_r5: assert property (@(posedge clk) disable iff (rst)
        lock_pulse_a |-> ($past(io_wr) && $past(io_addr) == 16'h0810));

    p_lockb_cause_r5: assert property (@(posedge clk) disable iff (rst)
        lock_pulse_b |-> ($past(io_wr) && $past(io_addr) == 16'h0812));

    p_lock_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(lock_pulse_a && lock_pulse_b));

    p_cache_hi_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(io_rd) && $past(io_addr) == 16'h081C && !$past(rst))
        |-> io_rdata[7:4] == 4'h0);

    p_hit_range_r10: assert property (@(posedge clk) disable iff (rst)
        win_hit |-> (cpu_addr >= 32'h8000_0000 && cpu_addr <= 32'h807F_FFFF));

    p_rdata_keep_r12: assert property (@(posedge clk) disable iff (rst)
        (!$past(io_rd) && !$past(rst)) |-> $stable(io_rdata));

endmodule

bind sysctl_bank sysctl_bank_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .io_addr      (io_addr),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_wdata     (io_wdata),
    .io_rdata     (io_rdata),
    .cpu_addr     (cpu_addr),
    .win_hit      (win_hit),
    .rst_req      (rst_req),
    .lock_pulse_a (lock_pulse_a),
    .lock_pulse_b (lock_pulse_b)
);

// File: tb/tb_sysctl_bank.sv
`timescale 1ns/1ps
module tb_sysctl_bank;

    localparam int O_RDATA = 0, O_RST = 1, O_LE = 2, O_LED = 3, O_CACHE = 4,
                   O_LOCKA = 5, O_LOCKB = 6, O_HIT = 7, O_PORT = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [31:0] cpu_addr = '0;
    logic        win_hit;
    logic [15:0] win_port;
    logic        rst_req, le_mode, disk_led, lock_pulse_a, lock_pulse_b;
    logic [3:0]  cache_ctl;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int due_now = 0;
    bit done = 0;

    int          q_sel[$];
    int          q_due[$];
    logic [15:0] q_exp[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    sysctl_bank dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_addr(cpu_addr),
        .win_hit(win_hit), .win_port(win_port), .rst_req(rst_req),
        .le_mode(le_mode), .disk_led(disk_led), .cache_ctl(cache_ctl),
        .lock_pulse_a(lock_pulse_a), .lock_pulse_b(lock_pulse_b)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] observe(int sel);
        case (sel)
            O_RDATA: return {8'h0, io_rdata};
            O_RST:   return {15'h0, rst_req};
            O_LE:    return {15'h0, le_mode};
            O_LED:   return {15'h0, disk_led};
            O_CACHE: return {12'h0, cache_ctl};
            O_LOCKA: return {15'h0, lock_pulse_a};
            O_LOCKB: return {15'h0, lock_pulse_b};
            O_HIT:   return {15'h0, win_hit};
            default: return win_port;
        endcase
    endfunction

    // monitor: compares items whose due cycle has arrived
    always @(posedge clk) begin
        #2;
        while (q_due.size() > 0 && q_due[0] <= cyc) begin
            logic [15:0] act;
            act = observe(q_sel[0]);
            checks++;
            if (act !== q_exp[0]) begin
                fails++;
                $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)",
                         q_tag[0], act, q_exp[0], cyc);
            end
            void'(q_sel.pop_front()); void'(q_due.pop_front());
            void'(q_exp.pop_front()); void'(q_tag.pop_front());
        end
    end

    task automatic expect_at(int sel, logic [15:0] exp, string tag, int due);
        q_sel.push_back(sel); q_exp.push_back(exp);
        q_tag.push_back(tag); q_due.push_back(due);
    endtask

    task automatic start_wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
        due_now = cyc + 1;
    endtask

    task automatic start_rd(logic [15:0] a);
        @(negedge clk);
        io_addr = a; io_wr = 1'b0; io_rd = 1'b1;
        due_now = cyc + 1;
    endtask

    task automatic finish_op();
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        due_now = cyc + 1;
    endtask

    task automatic read_check(logic [15:0] a, logic [7:0] exp, string tag);
        start_rd(a);
        expect_at(O_RDATA, {8'h0, exp}, tag, due_now);
        finish_op();
    endtask

    task automatic set_cpu(logic [31:0] a, logic hit, logic [15:0] p, string tag);
        @(negedge clk);
        cpu_addr = a;
        expect_at(O_HIT, {15'h0, hit}, tag, cyc + 1);
        if (hit) expect_at(O_PORT, p, tag, cyc + 1);
    endtask

    task automatic wait_drain();
        while (q_due.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        expect_at(O_RST, 0, "R1 rst_req", cyc + 1);
        expect_at(O_LE, 0, "R1 le_mode", cyc + 1);
        expect_at(O_LED, 0, "R1 disk_led", cyc + 1);
        expect_at(O_CACHE, 0, "R1 cache_ctl", cyc + 1);
        expect_at(O_LOCKA, 0, "R1 lock_a", cyc + 1);
        expect_at(O_LOCKB, 0, "R1 lock_b", cyc + 1);
        expect_at(O_RDATA, 0, "R1 rdata", cyc + 1);
        @(negedge clk);
        rst = 1'b0;
        expect_at(O_RDATA, 0, "R1 rdata after release", cyc + 1);
        expect_at(O_LOCKA, 0, "R1 lock_a after release", cyc + 1);
        // R1: map bit clear shows as flat translation
        set_cpu(32'h8012_3456, 1'b1, 16'h3456, "R1/R9 flat after reset");

        // R2: special port
        start_wr(16'h0092, 8'h03);
        expect_at(O_RST, 1, "R2 rst_req set", due_now);
        expect_at(O_LE, 1, "R2 le_mode set", due_now);
        finish_op();
        read_check(16'h0092, 8'h00, "R2 special reads zero");
        start_wr(16'h0092, 8'h02);
        expect_at(O_RST, 0, "R2 rst_req cleared", due_now);
        expect_at(O_LE, 1, "R2 le_mode kept", due_now);
        finish_op();
        start_wr(16'h0092, 8'h01);
        expect_at(O_RST, 1, "R2 rst_req again", due_now);
        expect_at(O_LE, 0, "R2 le_mode cleared", due_now);
        finish_op();
        start_wr(16'h0092, 8'h00);
        expect_at(O_RST, 0, "R2 rst_req low", due_now);
        finish_op();

        // R3: identification bytes, writes ignored
        start_wr(16'h0800, 8'h00);
        finish_op();
        start_wr(16'h0802, 8'h11);
        finish_op();
        start_wr(16'h0803, 8'h22);
        finish_op();
        read_check(16'h0800, 8'hEF, "R3 cpu id");
        read_check(16'h0802, 8'hAD, "R3 feature id");
        read_check(16'h0803, 8'hE0, "R3 status id");

        // R7: cache field
        start_wr(16'h081C, 8'hA7);
        expect_at(O_CACHE, 4'h7, "R7 cache low bits", due_now);
        finish_op();
        read_check(16'h081C, 8'h07, "R7 cache readback");

        // R4: light flag
        start_wr(16'h0808, 8'h01);
        expect_at(O_LED, 1, "R4 light on", due_now);
        expect_at(O_CACHE, 4'h7, "R4 cache kept", due_now);
        finish_op();
        start_wr(16'h0808, 8'hFE);
        expect_at(O_LED, 0, "R4 light off by bit0", due_now);
        finish_op();
        start_wr(16'h0808, 8'h01);
        finish_op();

        // R5: lock pulses
        start_wr(16'h0810, 8'h00);
        expect_at(O_LOCKA, 1, "R5 lock a high", due_now);
        expect_at(O_LOCKB, 0, "R5 lock b idle", due_now);
        finish_op();
        expect_at(O_LOCKA, 0, "R5 lock a one cycle", due_now);
        start_wr(16'h0812, 8'h5A);
        expect_at(O_LOCKB, 1, "R5 lock b high", due_now);
        expect_at(O_LOCKA, 0, "R5 lock a quiet", due_now);
        finish_op();
        expect_at(O_LOCKB, 0, "R5 lock b one cycle", due_now);
        start_wr(16'h0810, 8'hFF);
        expect_at(O_LOCKA, 1, "R5 back-to-back first", due_now);
        start_wr(16'h0810, 8'h00);
        expect_at(O_LOCKA, 1, "R5 back-to-back second", due_now);
        finish_op();
        expect_at(O_LOCKA, 0, "R5 lock a ends", due_now);
        expect_at(O_LED, 1, "R5 led untouched", due_now);

        // R6: fixed bytes
        read_check(16'h080C, 8'h3C, "R6 equipment");
        read_check(16'h0810, 8'h39, "R6 extended feature");
        read_check(16'h0818, 8'h00, "R6 keylock");
        read_check(16'h0823, 8'h03, "R6 l2 status");

        // R8 / R9: map bit and sparse translation
        start_wr(16'h0850, 8'hFE);
        finish_op();
        read_check(16'h0850, 8'h00, "R8 map bit0 clear");
        start_wr(16'h0850, 8'hFF);
        finish_op();
        read_check(16'h0850, 8'h01, "R8 map readback");
        set_cpu(32'h8012_3456, 1'b1, 16'h2476, "R9 sparse mid");
        set_cpu(32'h807F_F01F, 1'b1, 16'hFFFF, "R9 sparse top");

        // R10: window edges
        set_cpu(32'h8000_0000, 1'b1, 16'h0000, "R10 window start");
        set_cpu(32'h8080_0000, 1'b0, 16'h0000, "R10 past end");
        set_cpu(32'h7FFF_FFFF, 1'b0, 16'h0000, "R10 below start");

        // R11: undecoded and invalidate port
        start_wr(16'h0814, 8'hFF);
        finish_op();
        start_wr(16'h0830, 8'h00);
        expect_at(O_CACHE, 4'h7, "R11 cache unchanged", due_now);
        expect_at(O_LED, 1, "R11 led unchanged", due_now);
        expect_at(O_RST, 0, "R11 rst_req unchanged", due_now);
        finish_op();
        read_check(16'h0850, 8'h01, "R11 map unchanged");
        read_check(16'h0814, 8'hFF, "R11 invalidate reads FF");
        read_check(16'h0830, 8'hFF, "R11 hole reads FF");
        read_check(16'h0808, 8'hFF, "R11 light port reads FF");
        read_check(16'h0812, 8'hFF, "R11 lock2 port reads FF");

        // R12: read latency and hold
        start_rd(16'h0803);
        expect_at(O_RDATA, 8'hE0, "R12 due next cycle", due_now);
        finish_op();
        expect_at(O_RDATA, 8'hE0, "R12 held while idle", due_now);
        start_wr(16'h081C, 8'h03);
        expect_at(O_RDATA, 8'hE0, "R12 held across write", due_now);
        finish_op();

        wait_drain();
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule